// File: doc/BRIEF.md
# PAM3 Burst Symbol Encoder

This block turns one write burst into ternary line symbols for a data channel that is 11 lanes wide and 16 beats long. A burst carries 256 data bits, a poison flag, a severity flag and 18 CRC bits. The block cuts the data into 11-bit groups and one 3-bit remainder group. It cuts the CRC into 3-bit groups. Each group becomes the base-3 digits of its unsigned value, and the two flags share a single symbol. The resulting 176 symbols go out one beat at a time, 11 lanes per beat. The CRC value is computed elsewhere and arrives as an input field.

A matching decoder path sits in the same top. It gathers 16 received beats, rebuilds the data, flags and CRC, and raises an error for any symbol pattern that stands for no bit value. A controller uses the encoder on its transmit side and the decoder on its receive side. A bench or a link loopback can connect the two directly.

The trit codes on every lane are 2 bits: `00` is -1, `01` is 0, `10` is +1, and `11` is illegal. Under these codes a 2-bit lane value equals the base-3 digit (0, 1, 2) it carries.

Top module: `pam3_burst_codec`

## Requirements
- R1: After reset `enc_ready_o` is 1, while `sym_valid_o` and `dec_valid_o` are 0.
- R2: A burst is taken on a clock edge where `enc_valid_i` and `enc_ready_o` are both 1. Its beat 0 appears in the next cycle with `sym_valid_o` and `sym_first_o` set. Beats 1 to 15 follow in consecutive cycles with `sym_first_o` clear. After that `sym_valid_o` drops unless another burst was taken.
- R3: While a burst is being sent, `enc_ready_o` is 0 on beats 0 to 14 and 1 on beat 15. It is also 1 whenever the encoder is idle. A new burst offered on beat 15 starts on the very next cycle, giving one burst per 16 cycles. `enc_valid_i` and the burst fields are ignored while `enc_ready_o` is 0.
- R4: Symbol index i (0 to 175) is sent on beat i/11 and lane i%11. Lane l occupies bits [2l+1:2l] of the beat. The encoder never emits code `11`.
- R5: Data group g (g = 0 to 22) is data bits [11g+10:11g]. It is written as 7 base-3 digits, most significant first, at symbol indices 7g to 7g+6.
- R6: Data bits [255:253] are written as 2 base-3 digits, most significant first, at symbols 161 and 162.
- R7: Symbol 163 is the flag symbol. It holds `00` with neither flag set, `01` with poison only, and `10` whenever severity is set, whatever the poison flag.
- R8: CRC group c (c = 0 to 5) is CRC bits [3c+2:3c]. It is written as 2 base-3 digits, most significant first, at symbols 164+2c and 165+2c.
- R9: The decoder stores one beat per cycle while `rx_valid_i` is 1. A beat with `rx_first_i` set is stored as beat 0. In the cycle after the 16th beat is stored, `dec_valid_o` is 1 for exactly one cycle.
- R10: `dec_err_o` is 1 when any 7-symbol group has a base-3 value of 2048 or more.
- R11: `dec_err_o` is 1 when the remainder group or any CRC group has a 2-symbol value of 8 or more, that is, both digits are +1.
- R12: `dec_err_o` is 1 when any of the 176 received symbols carries code `11`, the flag symbol included.
- R13: For a burst with no code error, the decoder returns the original data and CRC. It reports severity for a flag symbol of `10` and poison for `01`, so poison is reported only when severity is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid_i | input | 1 | Burst offered to the encoder |
| enc_ready_o | output | 1 | Encoder can take a burst this cycle |
| enc_data_i | input | 256 | Burst data bits |
| enc_poison_i | input | 1 | Poison flag |
| enc_severity_i | input | 1 | Severity flag |
| enc_crc_i | input | 18 | CRC bits to send |
| sym_valid_o | output | 1 | A beat is on `sym_o` |
| sym_first_o | output | 1 | The beat on `sym_o` is beat 0 |
| sym_o | output | 22 | 11 lanes of 2-bit trit codes |
| rx_valid_i | input | 1 | A received beat is on `rx_sym_i` |
| rx_first_i | input | 1 | The received beat is beat 0 |
| rx_sym_i | input | 22 | 11 lanes of received trit codes |
| dec_valid_o | output | 1 | Decoded burst is on the outputs below |
| dec_data_o | output | 256 | Rebuilt data bits |
| dec_poison_o | output | 1 | Poison reported |
| dec_severity_o | output | 1 | Severity reported |
| dec_crc_o | output | 18 | Rebuilt CRC bits |
| dec_err_o | output | 1 | Some symbol pattern has no bit meaning |

## Verification
The bench builds the block with its default parameters: 11 lanes, 16 beats, 11-bit/7-symbol groups and 3-bit/2-symbol groups. The symbol layout only closes at exactly 176 positions, so no smaller configuration keeps every code kind present. At this size an exhaustive sweep is cheap. Every 11-bit value passes through data group 0 and back through the decoder. All 2187 seven-digit patterns, including the 139 unused ones, are injected into one group. All nine two-digit patterns go into the remainder group and a CRC group. An illegal code is placed at each of the 176 symbol positions in turn.

// File: rtl/pam3_pkg.sv
package pam3_pkg;

   // 2-bit lane code; the code value equals the base-3 digit it carries
   typedef logic [1:0] trit_t;

   localparam trit_t TRIT_NEG  = 2'b00;
   localparam trit_t TRIT_ZERO = 2'b01;
   localparam trit_t TRIT_POS  = 2'b10;
   localparam trit_t TRIT_BAD  = 2'b11;

   function automatic int pow3(input int n);
      int r;
      r = 1;
      for (int i = 0; i < n; i++) r = r * 3;
      return r;
   endfunction

   // severity dominates poison
   function automatic trit_t flag_to_trit(input logic poison, input logic severity);
      if (severity)    return TRIT_POS;
      else if (poison) return TRIT_ZERO;
      else             return TRIT_NEG;
   endfunction

endpackage

// File: rtl/pam3_grp_enc.sv
module pam3_grp_enc
   import pam3_pkg::*;
#(
   parameter int BITS  = 11,
   parameter int TRITS = 7
) (
   input  logic [BITS-1:0]    val_i,
   output logic [2*TRITS-1:0] sym_o   // symbol j at [2j+1:2j], j = 0 is most significant
);

   if (pow3(TRITS) < (2**BITS)) begin : g_bad_cfg
      $error("pam3_grp_enc: TRITS too small for BITS");
   end

   always_comb begin
      logic [BITS-1:0] rem;
      rem = val_i;
      sym_o = '0;
      for (int j = TRITS - 1; j >= 0; j--) begin
         sym_o[2*j +: 2] = 2'(rem % 3);
         rem = BITS'(rem / 3);
      end
   end

endmodule

// File: rtl/pam3_grp_dec.sv
module pam3_grp_dec
   import pam3_pkg::*;
#(
   parameter int BITS  = 11,
   parameter int TRITS = 7
) (
   input  logic [2*TRITS-1:0] sym_i,
   output logic [BITS-1:0]    val_o,
   output logic               err_o
);

   localparam int ACC_W = 2 * TRITS;
   localparam logic [ACC_W-1:0] LIMIT = ACC_W'(2**BITS);

   if (ACC_W <= BITS || pow3(TRITS) < (2**BITS)) begin : g_bad_cfg
      $error("pam3_grp_dec: inconsistent BITS/TRITS");
   end

   logic [ACC_W-1:0] acc;
   logic             code_bad;

   always_comb begin
      acc      = '0;
      code_bad = 1'b0;
      for (int j = 0; j < TRITS; j++) begin
         acc      = ACC_W'(acc * ACC_W'(3)) + ACC_W'(sym_i[2*j +: 2]);
         code_bad = code_bad | (sym_i[2*j +: 2] == TRIT_BAD);
      end
   end

   assign val_o = acc[BITS-1:0];
   assign err_o = code_bad | (acc >= LIMIT);

endmodule

// File: rtl/pam3_burst_codec.sv
module pam3_burst_codec
   import pam3_pkg::*;
#(
   parameter int LANES     = 11,
   parameter int BEATS     = 16,
   parameter int DATA_W    = 256,
   parameter int CRC_W     = 18,
   parameter int GRP_BITS  = 11,
   parameter int GRP_TRITS = 7,
   parameter int SUB_BITS  = 3,
   parameter int SUB_TRITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enc_valid_i,
   output logic                 enc_ready_o,
   input  logic [DATA_W-1:0]    enc_data_i,
   input  logic                 enc_poison_i,
   input  logic                 enc_severity_i,
   input  logic [CRC_W-1:0]     enc_crc_i,
   output logic                 sym_valid_o,
   output logic                 sym_first_o,
   output logic [2*LANES-1:0]   sym_o,
   input  logic                 rx_valid_i,
   input  logic                 rx_first_i,
   input  logic [2*LANES-1:0]   rx_sym_i,
   output logic                 dec_valid_o,
   output logic [DATA_W-1:0]    dec_data_o,
   output logic                 dec_poison_o,
   output logic                 dec_severity_o,
   output logic [CRC_W-1:0]     dec_crc_o,
   output logic                 dec_err_o
);

   localparam int DGRP      = DATA_W / GRP_BITS;
   localparam int TAIL_BITS = DATA_W - DGRP * GRP_BITS;
   localparam int TAIL_N    = (TAIL_BITS > 0) ? SUB_TRITS : 0;
   localparam int CGRP      = CRC_W / SUB_BITS;
   localparam int NSYM      = LANES * BEATS;
   localparam int TAIL_SYM  = DGRP * GRP_TRITS;
   localparam int FLAG_SYM  = TAIL_SYM + TAIL_N;
   localparam int CRC_SYM   = FLAG_SYM + 1;
   localparam int USED      = CRC_SYM + CGRP * SUB_TRITS;
   localparam int LINE_W    = 2 * LANES;
   localparam int FRAME_W   = 2 * NSYM;
   localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

   // ---------------- elaboration checks ----------------
   if (BEATS < 2) begin : g_bad_beats
      $error("pam3_burst_codec: BEATS must be at least 2");
   end
   if (TAIL_BITS > SUB_BITS) begin : g_bad_tail
      $error("pam3_burst_codec: data remainder wider than SUB_BITS");
   end
   if ((CRC_W % SUB_BITS) != 0) begin : g_bad_crc
      $error("pam3_burst_codec: CRC_W must be a multiple of SUB_BITS");
   end
   if (USED != NSYM) begin : g_bad_fill
      $error("pam3_burst_codec: symbol count does not fill LANES*BEATS");
   end

   // ---------------- encoder: bits to frame ----------------
   logic [FRAME_W-1:0] tx_frame;

   for (genvar g = 0; g < DGRP; g++) begin : g_denc
      pam3_grp_enc #(.BITS(GRP_BITS), .TRITS(GRP_TRITS)) u_enc (
         .val_i (enc_data_i[g*GRP_BITS +: GRP_BITS]),
         .sym_o (tx_frame[2*g*GRP_TRITS +: 2*GRP_TRITS])
      );
   end

   if (TAIL_BITS > 0) begin : g_tenc
      pam3_grp_enc #(.BITS(TAIL_BITS), .TRITS(SUB_TRITS)) u_enc (
         .val_i (enc_data_i[DATA_W-1 -: TAIL_BITS]),
         .sym_o (tx_frame[2*TAIL_SYM +: 2*SUB_TRITS])
      );
   end

   assign tx_frame[2*FLAG_SYM +: 2] = flag_to_trit(enc_poison_i, enc_severity_i);

   for (genvar c = 0; c < CGRP; c++) begin : g_cenc
      pam3_grp_enc #(.BITS(SUB_BITS), .TRITS(SUB_TRITS)) u_enc (
         .val_i (enc_crc_i[c*SUB_BITS +: SUB_BITS]),
         .sym_o (tx_frame[2*(CRC_SYM + c*SUB_TRITS) +: 2*SUB_TRITS])
      );
   end

   // ---------------- encoder: beat sequencer ----------------
   logic               busy_q;
   logic [BEAT_W-1:0]  beat_q;
   logic [FRAME_W-1:0] frame_q;
   logic               last_beat;
   logic               accept;

   assign last_beat   = busy_q && (beat_q == LAST_BEAT);
   assign enc_ready_o = !busy_q || last_beat;
   assign accept      = enc_valid_i && enc_ready_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         beat_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         beat_q <= '0;
      end else if (last_beat) begin
         busy_q <= 1'b0;
         beat_q <= '0;
      end else if (busy_q) begin
         beat_q <= beat_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) frame_q <= tx_frame;
   end

   assign sym_valid_o = busy_q;
   assign sym_first_o = busy_q && (beat_q == '0);
   assign sym_o       = frame_q[beat_q*LINE_W +: LINE_W];

   // ---------------- decoder: beat collector ----------------
   logic [BEAT_W-1:0]  rcnt_q;
   logic [BEAT_W-1:0]  ridx;
   logic [FRAME_W-1:0] rframe_q;
   logic               done_q;

   assign ridx = rx_first_i ? '0 : rcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rcnt_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= rx_valid_i && (ridx == LAST_BEAT);
         if (rx_valid_i) rcnt_q <= (ridx == LAST_BEAT) ? '0 : ridx + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rx_valid_i) rframe_q[ridx*LINE_W +: LINE_W] <= rx_sym_i;
   end

   // ---------------- decoder: frame to bits ----------------
   logic [DGRP-1:0] dgrp_err;
   logic [CGRP-1:0] cgrp_err;
   logic            tail_err;
   trit_t           flag_code;

   for (genvar g = 0; g < DGRP; g++) begin : g_ddec
      pam3_grp_dec #(.BITS(GRP_BITS), .TRITS(GRP_TRITS)) u_dec (
         .sym_i (rframe_q[2*g*GRP_TRITS +: 2*GRP_TRITS]),
         .val_o (dec_data_o[g*GRP_BITS +: GRP_BITS]),
         .err_o (dgrp_err[g])
      );
   end

   if (TAIL_BITS > 0) begin : g_tdec
      pam3_grp_dec #(.BITS(TAIL_BITS), .TRITS(SUB_TRITS)) u_dec (
         .sym_i (rframe_q[2*TAIL_SYM +: 2*SUB_TRITS]),
         .val_o (dec_data_o[DATA_W-1 -: TAIL_BITS]),
         .err_o (tail_err)
      );
   end else begin : g_no_tail
      assign tail_err = 1'b0;
   end

   for (genvar c = 0; c < CGRP; c++) begin : g_cdec
      pam3_grp_dec #(.BITS(SUB_BITS), .TRITS(SUB_TRITS)) u_dec (
         .sym_i (rframe_q[2*(CRC_SYM + c*SUB_TRITS) +: 2*SUB_TRITS]),
         .val_o (dec_crc_o[c*SUB_BITS +: SUB_BITS]),
         .err_o (cgrp_err[c])
      );
   end

   assign flag_code      = rframe_q[2*FLAG_SYM +: 2];
   assign dec_poison_o   = (flag_code == TRIT_ZERO);
   assign dec_severity_o = (flag_code == TRIT_POS);
   assign dec_err_o      = (|dgrp_err) | (|cgrp_err) | tail_err | (flag_code == TRIT_BAD);
   assign dec_valid_o    = done_q;

endmodule

// File: rtl/pam3_burst_codec_chk.sv
module pam3_burst_codec_chk #(
   parameter int LINE_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enc_valid_i,
   input logic              enc_ready_o,
   input logic              sym_valid_o,
   input logic              sym_first_o,
   input logic [LINE_W-1:0] sym_o,
   input logic              dec_valid_o
);

   logic lane_bad;

   always_comb begin
      lane_bad = 1'b0;
      for (int l = 0; l < LINE_W / 2; l++)
         lane_bad = lane_bad | (sym_o[2*l +: 2] == 2'b11);
   end

   // R2
   accept_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid_i && enc_ready_o |=> sym_valid_o && sym_first_o);

   // R2
   burst_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid_o && !enc_ready_o |=> sym_valid_o && !sym_first_o);

   // R3
   first_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_first_o |-> !enc_ready_o);

   // R3
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_valid_o |-> enc_ready_o);

   // R4
   no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid_o |-> !lane_bad);

   // R9
   dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_o |=> !dec_valid_o);

endmodule

bind pam3_burst_codec pam3_burst_codec_chk #(.LINE_W(2*LANES)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .enc_valid_i (enc_valid_i),
   .enc_ready_o (enc_ready_o),
   .sym_valid_o (sym_valid_o),
   .sym_first_o (sym_first_o),
   .sym_o       (sym_o),
   .dec_valid_o (dec_valid_o)
);

// File: tb/pam3_burst_codec_test.sv
module pam3_burst_codec_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enc_valid = 1'b0;
   logic         enc_ready;
   logic [255:0] enc_data = '0;
   logic         enc_poison = 1'b0;
   logic         enc_severity = 1'b0;
   logic [17:0]  enc_crc = '0;
   logic         sym_valid;
   logic         sym_first;
   logic [21:0]  sym;
   logic         rx_valid = 1'b0;
   logic         rx_first = 1'b0;
   logic [21:0]  rx_sym = '0;
   logic         dec_valid;
   logic [255:0] dec_data;
   logic         dec_poison;
   logic         dec_severity;
   logic [17:0]  dec_crc;
   logic         dec_err;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pam3_burst_codec uut (
      .clk(clk), .rst_n(rst_n),
      .enc_valid_i(enc_valid), .enc_ready_o(enc_ready),
      .enc_data_i(enc_data), .enc_poison_i(enc_poison),
      .enc_severity_i(enc_severity), .enc_crc_i(enc_crc),
      .sym_valid_o(sym_valid), .sym_first_o(sym_first), .sym_o(sym),
      .rx_valid_i(rx_valid), .rx_first_i(rx_first), .rx_sym_i(rx_sym),
      .dec_valid_o(dec_valid), .dec_data_o(dec_data),
      .dec_poison_o(dec_poison), .dec_severity_o(dec_severity),
      .dec_crc_o(dec_crc), .dec_err_o(dec_err)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [351:0] act, input logic [351:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int pw3(input int n);
      int r = 1;
      for (int i = 0; i < n; i++) r = r * 3;
      return r;
   endfunction

   // expected line frame, symbol i at bits [2i+1:2i]
   function automatic logic [351:0] exp_frame(input logic [255:0] d, input logic p,
                                              input logic s, input logic [17:0] c);
      logic [351:0] f = '0;
      for (int g = 0; g < 23; g++) begin
         int v = int'(d[11*g +: 11]);
         for (int j = 0; j < 7; j++) f[2*(7*g + j) +: 2] = 2'((v / pw3(6 - j)) % 3);
      end
      begin
         int v = int'(d[255:253]);
         for (int j = 0; j < 2; j++) f[2*(161 + j) +: 2] = 2'((v / pw3(1 - j)) % 3);
      end
      f[2*163 +: 2] = s ? 2'b10 : (p ? 2'b01 : 2'b00);
      for (int k = 0; k < 6; k++) begin
         int v = int'(c[3*k +: 3]);
         for (int j = 0; j < 2; j++) f[2*(164 + 2*k + j) +: 2] = 2'((v / pw3(1 - j)) % 3);
      end
      return f;
   endfunction

   // called in the cycle that shows beat 0; returns in the cycle of beat 15
   task automatic grab(output logic [351:0] fr, output bit seq_ok);
      seq_ok = 1;
      fr = '0;
      fr[0 +: 22] = sym;
      for (int b = 1; b < 16; b++) begin
         @(posedge clk); #1;
         if (!(sym_valid && !sym_first)) seq_ok = 0;
         fr[22*b +: 22] = sym;
      end
   endtask

   task automatic send(input logic [255:0] d, input logic p, input logic s,
                       input logic [17:0] c, output logic [351:0] fr);
      bit seq_ok;
      enc_data = d; enc_poison = p; enc_severity = s; enc_crc = c;
      enc_valid = 1;
      @(posedge clk); #1;
      enc_valid = 0;
      chk(sym_valid && sym_first, "R2 beat0 follows accept", {sym_valid, sym_first}, 2'b11);
      grab(fr, seq_ok);
      chk(seq_ok, "R2 beats 1-15 contiguous", seq_ok, 1);
      @(posedge clk); #1;
      chk(!sym_valid, "R2 valid ends after 16 beats", sym_valid, 0);
   endtask

   task automatic replay(input logic [351:0] fr);
      for (int b = 0; b < 16; b++) begin
         rx_valid = 1; rx_first = (b == 0); rx_sym = fr[22*b +: 22];
         @(posedge clk); #1;
      end
      rx_valid = 0; rx_first = 0;
   endtask

   task automatic cmp_frame(input logic [351:0] a, input logic [351:0] e);
      chk(a[0 +: 322] == e[0 +: 322], "R5 data groups / R4 layout", a[0 +: 322], e[0 +: 322]);
      chk(a[322 +: 4] == e[322 +: 4], "R6 remainder group", a[322 +: 4], e[322 +: 4]);
      chk(a[326 +: 2] == e[326 +: 2], "R7 flag symbol", a[326 +: 2], e[326 +: 2]);
      chk(a[328 +: 24] == e[328 +: 24], "R8 CRC groups", a[328 +: 24], e[328 +: 24]);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [351:0] fr, fr2, base;
      logic [255:0] d;
      logic [17:0]  c;
      logic         p, s;
      bit           ok;

      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1
      chk(enc_ready && !sym_valid && !dec_valid, "R1 reset state",
          {enc_ready, sym_valid, dec_valid}, 3'b100);

      // R5 R6 R7 R8 R13 sweep every 11-bit value through group 0
      for (int v = 0; v < 2048; v++) begin
         d = '0; c = '0;
         for (int g = 0; g < 23; g++) d[11*g +: 11] = 11'((v + g*89) % 2048);
         d[255:253] = 3'(v % 8);
         for (int k = 0; k < 6; k++) c[3*k +: 3] = 3'((v + k) % 8);
         p = 1'(v % 2); s = 1'((v / 2) % 2);
         send(d, p, s, c, fr);
         cmp_frame(fr, exp_frame(d, p, s, c));
         replay(fr);
         chk(dec_valid, "R9 dec_valid after 16th beat", dec_valid, 1);
         chk(dec_data == d && dec_crc == c && !dec_err, "R13 data/crc restored",
             {dec_err, dec_crc, dec_data}, {1'b0, c, d});
         chk(dec_severity == s && dec_poison == (p && !s), "R13 flags restored",
             {dec_severity, dec_poison}, {s, p && !s});
         @(posedge clk); #1;
         chk(!dec_valid, "R9 single-cycle dec_valid", dec_valid, 0);
      end

      // R3 input ignored while ready is low
      begin
         logic [255:0] da = {8{32'hA5C3_1E77}};
         logic [17:0]  ca = 18'h2_D1C;
         bit seq_ok;
         enc_data = da; enc_poison = 1; enc_severity = 0; enc_crc = ca;
         enc_valid = 1;
         @(posedge clk); #1;
         enc_data = ~da; enc_poison = 0; enc_severity = 1; enc_crc = ~ca;
         fr = '0; fr[0 +: 22] = sym;
         for (int b = 1; b < 16; b++) begin
            @(posedge clk); #1;
            if (b == 10) enc_valid = 0;
            fr[22*b +: 22] = sym;
         end
         chk(fr == exp_frame(da, 1, 0, ca), "R3 mid-burst input ignored", fr, exp_frame(da, 1, 0, ca));
         @(posedge clk); #1;
         chk(!sym_valid, "R3 no burst taken while not ready", sym_valid, 0);
         seq_ok = 1;
      end

      // R3 back-to-back bursts
      begin
         logic [255:0] dx = {16{16'h3B29}};
         logic [255:0] dy = {16{16'hE4F0}};
         logic [17:0]  cx = 18'h1_2345;
         logic [17:0]  cy = 18'h3_0F0F;
         bit ready_ok, seq_ok;
         enc_data = dx; enc_poison = 0; enc_severity = 0; enc_crc = cx;
         enc_valid = 1;
         @(posedge clk); #1;
         enc_data = dy; enc_poison = 1; enc_severity = 1; enc_crc = cy;
         ready_ok = 1; fr = '0;
         for (int b = 0; b < 16; b++) begin
            if (b > 0) begin @(posedge clk); #1; end
            fr[22*b +: 22] = sym;
            if (enc_ready != (b == 15)) ready_ok = 0;
         end
         chk(ready_ok, "R3 ready only on beat 15", ready_ok, 1);
         @(posedge clk); #1;
         enc_valid = 0;
         chk(sym_valid && sym_first, "R3 next burst 16 cycles later", {sym_valid, sym_first}, 2'b11);
         grab(fr2, seq_ok);
         chk(fr == exp_frame(dx, 0, 0, cx), "R3 first of pair", fr, exp_frame(dx, 0, 0, cx));
         chk(fr2 == exp_frame(dy, 1, 1, cy), "R3 second of pair / R7 both flags",
             fr2, exp_frame(dy, 1, 1, cy));
         @(posedge clk); #1;
      end

      base = exp_frame('0, 0, 0, '0);

      // R10 every 7-digit pattern in group 0
      for (int q = 0; q < 2187; q++) begin
         fr = base;
         for (int j = 0; j < 7; j++) fr[2*j +: 2] = 2'((q / pw3(6 - j)) % 3);
         replay(fr);
         ok = (dec_err == (q >= 2048)) && (q >= 2048 || dec_data[10:0] == 11'(q));
         chk(dec_valid && ok, "R10 7-symbol group range", {dec_valid, dec_err, dec_data[10:0]},
             {1'b1, 1'(q >= 2048), 11'(q)});
      end

      // R11 every 2-digit pattern in the remainder group and CRC group 0, pattern 8 in group 5
      for (int q = 0; q < 9; q++) begin
         fr = base;
         fr[2*161 +: 2] = 2'(q / 3); fr[2*162 +: 2] = 2'(q % 3);
         replay(fr);
         ok = (dec_err == (q >= 8)) && (q >= 8 || dec_data[255:253] == 3'(q));
         chk(ok, "R11 remainder group range", {dec_err, dec_data[255:253]}, {1'(q >= 8), 3'(q)});
         fr = base;
         fr[2*164 +: 2] = 2'(q / 3); fr[2*165 +: 2] = 2'(q % 3);
         replay(fr);
         ok = (dec_err == (q >= 8)) && (q >= 8 || dec_crc[2:0] == 3'(q));
         chk(ok, "R11 CRC group range", {dec_err, dec_crc[2:0]}, {1'(q >= 8), 3'(q)});
      end
      fr = base;
      fr[2*174 +: 2] = 2'b10; fr[2*175 +: 2] = 2'b10;
      replay(fr);
      chk(dec_err, "R11 last CRC group value 8", dec_err, 1);

      // R12 illegal code at each position
      for (int i = 0; i < 176; i++) begin
         fr = base;
         fr[2*i +: 2] = 2'b11;
         replay(fr);
         chk(dec_valid && dec_err, "R12 illegal code flagged", {dec_valid, dec_err}, 2'b11);
      end

      // R9 first marker resynchronises the collector
      fr = exp_frame({8{32'h0BAD_F00D}}, 0, 1, 18'h0_1234);
      for (int b = 0; b < 5; b++) begin
         rx_valid = 1; rx_first = (b == 0); rx_sym = 22'h3F_FFFF;
         @(posedge clk); #1;
      end
      replay(fr);
      chk(dec_valid && !dec_err && dec_data == {8{32'h0BAD_F00D}} && dec_crc == 18'h0_1234,
          "R9 restart on first marker", {dec_valid, dec_err, dec_crc}, {1'b1, 1'b0, 18'h0_1234});

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule